// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Filter

This block watches the digitised LIN bus while the transceiver rests in one of its two low-power modes and raises a single-cycle wake request when the bus carries a genuine remote wake-up: the bus must leave the recessive level, stay dominant for longer than the filter time, and then return to recessive. The request fires on that return to recessive. A bus that is already shorted low when the node goes to rest therefore never wakes it. A short that appears after the node is at rest wakes it only when the short is cleared.

The bus is only treated as dominant while the analog front end also reports that the level is below the pre-wake threshold. Both bus inputs pass through a clock-domain synchroniser. The mode controller supplies the operating mode, the transmit-pin level and a supply-undervoltage flag, all in the block's own clock domain. From silent mode a wake-up is accepted only while the transmit pin is high. From sleep mode a wake-up is accepted only while the supply is not in undervoltage. After one request the detector stays quiet until the mode controller leaves the low-power modes and enters one again.

The filter time is a parameter counted in clock cycles. At 200 MHz, a nominal 100 µs corresponds to 20000 cycles, and the allowed spread runs from 50 µs to 150 µs.

Top module: `lwf_wake_filter`

## Requirements
- R1: While rst_n is low, wake_req_o is low, and after reset the detector starts idle.
- R2: bus_rx_i and prewake_i each pass through a two-stage synchroniser. After the bus returns to recessive at the end of a qualified pattern, wake_req_o is high during the cycle that follows the third rising clock edge after the change.
- R3: The bus counts as dominant only when bus_rx_i is 0 and prewake_i is 1. A wake needs more than FILTER_CYC consecutive dominant samples and then a recessive sample. A dominant run of exactly FILTER_CYC samples gives no request and clears the timer.
- R4: A dominant level must follow a recessive level seen after entry to a low-power mode. A bus held dominant from before entry gives no request, not even when it is released.
- R5: A bus that turns dominant while the detector is armed and stays dominant gives no request until it returns to recessive. The request then comes on that release.
- R6: While prewake_i is 0, a dominant bus_rx_i is treated as recessive and starts no filtering.
- R7: In silent mode a wake is accepted only while txd_i is 1. If txd_i is 0, any pattern in progress is dropped and a fresh recessive-to-dominant change is needed. vs_uv_i has no effect in silent mode.
- R8: In sleep mode a wake is accepted only while vs_uv_i is 0. If vs_uv_i rises, any pattern in progress is dropped and a fresh recessive-to-dominant change is needed. txd_i has no effect in sleep mode.
- R9: wake_req_o is high for exactly one cycle. After that, no further request comes until mode_i leaves the low-power modes and returns to one of them.
- R10: mode_i uses the codes 2'b00 normal, 2'b01 fail-safe, 2'b10 silent and 2'b11 sleep. In normal and fail-safe modes the detector is disarmed and never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rx_i | input | 1 | Digitised bus level, 1 recessive, 0 dominant (asynchronous) |
| prewake_i | input | 1 | Bus below pre-wake threshold flag (asynchronous) |
| mode_i | input | 2 | Operating mode from the mode controller |
| txd_i | input | 1 | Transmit pin level |
| vs_uv_i | input | 1 | Supply undervoltage flag |
| wake_req_o | output | 1 | Single-cycle remote wake request |

## Verification
Some internal faults leave the sequencer in the wrong state, for example a missed arm, a lost dominant phase or a request state that is never left. Each of these shows at wake_req_o as a missing, early, late or repeated pulse. The pulse is due exactly three edges after the bus release, so such a fault shows up within a few cycles of the release. A miscounted filter timer moves the threshold between no request and a request by one dominant sample, so the bench probes runs of FILTER_CYC and FILTER_CYC+1 samples. Gate faults on txd_i, vs_uv_i or mode_i show as a pulse in a case where the expected count is zero. A per-cycle reference model catches any wrong cycle.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_FAILSAFE = 2'b01,
        MODE_SILENT   = 2'b10,
        MODE_SLEEP    = 2'b11
    } lin_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,      // not in a low-power mode
        ST_SEEK_REC,  // armed, waiting for a recessive level
        ST_READY,     // recessive seen, waiting for a dominant start
        ST_DOM,       // dominant, filter timer running
        ST_QUAL,      // dominant longer than the filter time
        ST_SPENT      // request issued, waiting for mode re-entry
    } wake_st_e;

    typedef struct packed {
        wake_st_e st;
        logic     wake;
    } wake_fsm_t;

endpackage

// File: rtl/lwf_sync.sv
module lwf_sync #(
    parameter int unsigned          WIDTH   = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/lwf_gate.sv
module lwf_gate
    import lwf_pkg::*;
(
    input  lin_mode_e mode_i,
    input  logic      txd_i,
    input  logic      vs_uv_i,
    output logic      low_power_o,
    output logic      accept_o
);

    always_comb begin
        low_power_o = 1'b0;
        accept_o    = 1'b0;
        unique case (mode_i)
            MODE_SILENT: begin
                low_power_o = 1'b1;
                accept_o    = txd_i;
            end
            MODE_SLEEP: begin
                low_power_o = 1'b1;
                accept_o    = !vs_uv_i;
            end
            default: begin
                low_power_o = 1'b0;
                accept_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lwf_timer.sv
module lwf_timer #(
    parameter int unsigned LIMIT = 20000,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(LIMIT)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/lwf_wake_filter.sv
module lwf_wake_filter
    import lwf_pkg::*;
#(
    parameter int unsigned FILTER_CYC  = 20000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rx_i,
    input  logic       prewake_i,
    input  logic [1:0] mode_i,
    input  logic       txd_i,
    input  logic       vs_uv_i,
    output logic       wake_req_o
);

    localparam int unsigned CNT_W = $clog2(FILTER_CYC + 1);

    logic [1:0]       raw_w, syn_w;
    logic             bus_dom;
    logic             low_power, accept;
    logic             timer_run, timer_done;
    logic [CNT_W-1:0] timer_cnt;
    wake_fsm_t        fsm_d, fsm_q;

    // bit 0 bus level (resets recessive), bit 1 pre-wake flag (resets clear)
    assign raw_w = {prewake_i, bus_rx_i};

    lwf_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (syn_w)
    );

    assign bus_dom = !syn_w[0] && syn_w[1];

    lwf_gate u_gate (
        .mode_i      (lin_mode_e'(mode_i)),
        .txd_i       (txd_i),
        .vs_uv_i     (vs_uv_i),
        .low_power_o (low_power),
        .accept_o    (accept)
    );

    lwf_timer #(
        .LIMIT (FILTER_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .cnt_o  (timer_cnt),
        .done_o (timer_done)
    );

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.wake = 1'b0;
        if (!low_power) begin
            fsm_d.st = ST_IDLE;
        end else begin
            unique case (fsm_q.st)
                ST_IDLE: begin
                    fsm_d.st = ST_SEEK_REC;
                end
                ST_SEEK_REC: begin
                    if (!bus_dom) fsm_d.st = ST_READY;
                end
                ST_READY: begin
                    if (bus_dom) begin
                        fsm_d.st = accept ? ST_DOM : ST_SEEK_REC;
                    end
                end
                ST_DOM: begin
                    if (!accept) begin
                        fsm_d.st = ST_SEEK_REC;
                    end else if (!bus_dom) begin
                        fsm_d.st = ST_READY;
                    end else if (timer_done) begin
                        fsm_d.st = ST_QUAL;
                    end
                end
                ST_QUAL: begin
                    if (!accept) begin
                        fsm_d.st = ST_SEEK_REC;
                    end else if (!bus_dom) begin
                        fsm_d.st   = ST_SPENT;
                        fsm_d.wake = 1'b1;
                    end
                end
                ST_SPENT: begin
                    fsm_d.st = ST_SPENT;
                end
                default: begin
                    fsm_d.st = ST_IDLE;
                end
            endcase
        end
    end

    assign timer_run = (fsm_d.st == ST_DOM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, wake: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign wake_req_o = fsm_q.wake;

endmodule

// File: rtl/lwf_wake_filter_chk.sv
module lwf_wake_filter_chk
    import lwf_pkg::*;
#(
    parameter int unsigned LIMIT = 1,
    parameter int unsigned CW    = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          txd_i,
    input logic          vs_uv_i,
    input logic          wake_req_o,
    input logic          bus_dom,
    input logic [CW-1:0] cnt
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o); // R9

    AST_WAKE_ONLY_LOW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> ($past(mode_i) == MODE_SILENT || $past(mode_i) == MODE_SLEEP)); // R10

    AST_SILENT_NEEDS_TXD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && $past(mode_i) == MODE_SILENT) |-> $past(txd_i)); // R7

    AST_SLEEP_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && $past(mode_i) == MODE_SLEEP) |-> !$past(vs_uv_i)); // R8

    AST_WAKE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (!$past(bus_dom) && $past(bus_dom, 2))); // R3

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= LIMIT); // R3

endmodule

bind lwf_wake_filter lwf_wake_filter_chk #(
    .LIMIT (FILTER_CYC),
    .CW    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .txd_i      (txd_i),
    .vs_uv_i    (vs_uv_i),
    .wake_req_o (wake_req_o),
    .bus_dom    (bus_dom),
    .cnt        (timer_cnt)
);

// File: tb/test_lwf_wake_filter.sv
`timescale 1ns/1ps
module test_lwf_wake_filter;

    localparam int F = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rx = 1'b1;
    logic       prew = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       txd = 1'b1;
    logic       uv = 1'b0;
    logic       wake_req;

    int    checks = 0;
    int    fails = 0;
    int    pulses = 0;
    bit    done_flag = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    lwf_wake_filter #(.FILTER_CYC(F)) i_lwf_wake_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rx_i   (bus_rx),
        .prewake_i  (prew),
        .mode_i     (mode),
        .txd_i      (txd),
        .vs_uv_i    (uv),
        .wake_req_o (wake_req)
    );

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: integer pipeline for the synchroniser,
    // phase number for the pattern progress.
    // phase: 0 off, 1 need recessive, 2 ready, 3 dominant, 4 qualified, 5 used
    int m_b1, m_b2, m_p1, m_p2, m_phase, m_run;
    bit m_wake;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_b1 = 1; m_b2 = 1; m_p1 = 0; m_p2 = 0;
            m_phase = 0; m_run = 0; m_wake = 0;
        end else begin
            bit dom, armed, allow;
            dom   = (m_b2 == 0) && (m_p2 == 1);
            armed = (mode == 2'b10) || (mode == 2'b11);
            allow = (mode == 2'b10) ? txd : ((mode == 2'b11) ? !uv : 1'b0);
            m_wake = 0;
            if (!armed) begin
                m_phase = 0; m_run = 0;
            end else if (m_phase == 0) begin
                m_phase = 1;
            end else if (m_phase == 1) begin
                if (!dom) m_phase = 2;
            end else if (m_phase == 2) begin
                if (dom && allow) begin m_phase = 3; m_run = 1; end
                else if (dom) m_phase = 1;
            end else if (m_phase == 3) begin
                if (!allow) begin m_phase = 1; m_run = 0; end
                else if (!dom) begin m_phase = 2; m_run = 0; end
                else if (m_run > F) m_phase = 4;
                else m_run++;
                if (m_phase == 3 && m_run > F) m_phase = 4;
            end else if (m_phase == 4) begin
                if (!allow) begin m_phase = 1; m_run = 0; end
                else if (!dom) begin m_phase = 5; m_wake = 1; m_run = 0; end
            end
            m_b2 = m_b1; m_b1 = bus_rx;
            m_p2 = m_p1; m_p1 = prew;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk(cur_req, wake_req, m_wake, "per-cycle model compare");
            if (wake_req === 1'b1) pulses++;
        end
    end

    task automatic hold(bit b, bit p, int n);
        bus_rx = b;
        prew = p;
        repeat (n) @(negedge clk);
    endtask

    task automatic pattern(int dom_len);
        hold(1, 0, 6);
        hold(0, 1, dom_len);
        hold(1, 0, 8);
    endtask

    task automatic enter(logic [1:0] m);
        mode = 2'b00;
        hold(1, 0, 4);
        mode = m;
        hold(1, 0, 4);
    endtask

    task automatic expect_pulses(string req, int exp, string what);
        chk_int(req, pulses, exp, what);
        pulses = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", wake_req, 1'b0, "output during reset");
        rst_n = 1'b1;
        hold(1, 0, 4);
        chk("R1", wake_req, 1'b0, "output after reset");

        // R10: disarmed in normal and fail-safe modes
        cur_req = "R10";
        mode = 2'b00; pattern(F + 5);
        mode = 2'b01; pattern(F + 5);
        expect_pulses("R10", 0, "pulses in normal/fail-safe");

        // R3: valid pattern in sleep
        cur_req = "R3";
        enter(2'b11); uv = 0;
        pattern(F + 5);
        expect_pulses("R3", 1, "pulses for long dominant in sleep");

        // R9: disarmed after one request, re-armed by mode re-entry
        cur_req = "R9";
        pattern(F + 5);
        expect_pulses("R9", 0, "pulses before re-entry");
        enter(2'b11);
        pattern(F + 5);
        expect_pulses("R9", 1, "pulses after re-entry");

        // R3: boundary, exactly F samples then F+1
        cur_req = "R3";
        enter(2'b11);
        pattern(F);
        expect_pulses("R3", 0, "pulses for exactly FILTER_CYC dominant");
        pattern(F + 1);
        expect_pulses("R3", 1, "pulses for FILTER_CYC+1 dominant");

        // R6: dominant without pre-wake flag is recessive
        cur_req = "R6";
        enter(2'b11);
        hold(1, 0, 6); hold(0, 0, 2 * F); hold(1, 0, 8);
        expect_pulses("R6", 0, "pulses without pre-wake flag");
        pattern(F + 5);
        expect_pulses("R6", 1, "pulses with pre-wake flag");

        // R4: shorted before entry
        cur_req = "R4";
        mode = 2'b00; hold(0, 1, 4);
        mode = 2'b11; hold(0, 1, 2 * F); hold(1, 0, 8);
        expect_pulses("R4", 0, "pulses for short present at entry");
        pattern(F + 5);
        expect_pulses("R4", 1, "pulses for later valid pattern");

        // R5: short appears after arming
        cur_req = "R5";
        enter(2'b11);
        hold(1, 0, 6); hold(0, 1, 3 * F);
        expect_pulses("R5", 0, "pulses while short held");
        hold(1, 0, 8);
        expect_pulses("R5", 1, "pulses on short removal");

        // R7: silent mode gated by txd, uv ignored
        cur_req = "R7";
        txd = 0; enter(2'b10);
        pattern(F + 5);
        expect_pulses("R7", 0, "pulses in silent with txd low");
        txd = 1; uv = 1;
        pattern(F + 5);
        expect_pulses("R7", 1, "pulses in silent with txd high, uv set");
        uv = 0;

        // R7: txd drop mid-pattern aborts
        enter(2'b10);
        hold(1, 0, 6); hold(0, 1, F / 2);
        txd = 0; hold(0, 1, 2);
        txd = 1; hold(0, 1, 2 * F); hold(1, 0, 8);
        expect_pulses("R7", 0, "pulses after txd drop mid-pattern");

        // R8: sleep mode gated by supply, txd ignored
        cur_req = "R8";
        uv = 1; enter(2'b11);
        pattern(F + 5);
        expect_pulses("R8", 0, "pulses in sleep with undervoltage");
        uv = 0;
        enter(2'b11);
        hold(1, 0, 6); hold(0, 1, F / 2);
        uv = 1; hold(0, 1, 3);
        uv = 0; hold(0, 1, 2 * F); hold(1, 0, 8);
        expect_pulses("R8", 0, "pulses after undervoltage mid-pattern");
        txd = 0;
        pattern(F + 5);
        expect_pulses("R8", 1, "pulses in sleep with txd low");
        txd = 1;

        // R2: latency of three edges, R9 width of one cycle
        cur_req = "R2";
        enter(2'b11);
        hold(1, 0, 6); hold(0, 1, F + 5);
        bus_rx = 1; prew = 0;
        repeat (2) @(negedge clk);
        chk("R2", wake_req, 1'b0, "before third edge after release");
        @(negedge clk);
        chk("R2", wake_req, 1'b1, "after third edge after release");
        @(negedge clk);
        chk("R9", wake_req, 1'b0, "cycle after pulse");
        hold(1, 0, 4);
        expect_pulses("R2", 1, "pulses in latency probe");

        mode = 2'b00;
        hold(1, 0, 4);
        finish_run();
    end

endmodule